// File: doc/BRIEF.md
# Linked State Machine Batch Mixing Controller

This block sequences a batch mixing plant. Aggregate and content are each metered from their own feeder onto one shared scale. The weighed charge is then dumped into a mixer together with water, mixed for a timed interval and unloaded. The control flow is a concurrent net. It is split into three cooperating Moore machines:

- The aggregate machine fills the aggregate feeder, weighs aggregate onto the scale, then waits for the scale to empty.
- The content machine fills the content feeder, waits, weighs content and dumps the scale.
- The mixer machine waits for a charge, runs the mixer and then drains it.

Each machine publishes a flag while it occupies a place that another machine must synchronise with. Fork and join points are reproduced by making each participating machine check the flags of its peers. Because all machines share one clock and evaluate the same flags, every side of a join or fork fires on the same edge.

All sensors are level inputs sampled on the rising clock edge. The mixing timer lives outside the block and is seen only as a done input. Commands are Moore outputs, valid one cycle after the edge at which a transition's condition held. The scale inlet gate is driven by two machines and is their OR.

Top module: `lsm_batch_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are fill_agg=1, fill_cont=1, scale_gate=0, scale_dump=0, mix_run=0, mix_drain=0, whatever state the machines were in.
- R2: While the aggregate feeder is being filled (fill_agg=1), `agg_full` high at an edge ends filling and opens `scale_gate` for aggregate weighing from the next cycle.
- R3: While the content feeder is being filled (fill_cont=1), `cont_full` high at an edge stops filling, and the content machine waits with no command of its own.
- R4: Aggregate weighing hands over to content weighing only at an edge where `scale_lo` is high, aggregate is weighing and content is ready. Until then aggregate weighing continues even with `scale_lo` high.
- R5: Content weighing ends with `scale_dump`=1 only at an edge where `scale_hi` is high and the mixer machine is idle. While the mixer runs or drains, the scale stays gated.
- R6: At an edge where `scale_lo` is low during a dump, the fork fires. On the next cycle `scale_dump` is 0 and mix_run, fill_agg and fill_cont are all 1. While `scale_lo` stays high the dump holds.
- R7: mix_run stays on until an edge with `mix_done` high. mix_drain then stays on until an edge with `mix_empty` high, after which the mixer is idle and no new dump starts on that same edge.
- R8: Aggregate filling and weighing for the next batch proceed while mix_run is on.
- R9: A sensor that no transition of the current state looks at has no effect: every machine holds its state and its outputs.
- R10: `scale_gate` is the OR of the aggregate and content weighing commands, and the two weighing phases never overlap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| agg_full | input | 1 | Aggregate feeder at high level |
| cont_full | input | 1 | Content feeder at high level |
| scale_lo | input | 1 | Scale at or above the aggregate target |
| scale_hi | input | 1 | Scale at or above the total target |
| mix_done | input | 1 | External mixing timer expired |
| mix_empty | input | 1 | Mixer vessel empty |
| fill_agg | output | 1 | Aggregate feeder fill command |
| fill_cont | output | 1 | Content feeder fill command |
| scale_gate | output | 1 | Scale inlet gate (merged from two machines) |
| scale_dump | output | 1 | Scale discharge and water valve into mixer |
| mix_run | output | 1 | Mixer motor |
| mix_drain | output | 1 | Mixer unload valve |

## Verification
Every transition is one register deep, so each command reflects the sensor values of exactly one edge earlier. The vector walk drives sensors on the falling edge, lets one rising edge pass and compares all six commands on the following falling edge. Join and fork cases are therefore checked in the single cycle in which all machines must move together. A reactive plant model then runs several batches and checks the order of the commands over the whole run.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

   // aggregate machine places
   typedef enum logic [1:0] {
      AG_FILL  = 2'd0,
      AG_WEIGH = 2'd1,
      AG_SYNC  = 2'd2
   } agg_st_e;

   // content machine places
   typedef enum logic [1:0] {
      CT_FILL  = 2'd0,
      CT_READY = 2'd1,
      CT_WEIGH = 2'd2,
      CT_DUMP  = 2'd3
   } cnt_st_e;

   // mixer machine places
   typedef enum logic [1:0] {
      MX_IDLE   = 2'd0,
      MX_CHARGE = 2'd1,
      MX_RUN    = 2'd2,
      MX_DRAIN  = 2'd3
   } mix_st_e;

endpackage

// File: rtl/lsm_agg_fsm.sv
module lsm_agg_fsm
   import lsm_pkg::*;
#(
   parameter int unsigned OUT_REG = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic agg_full,
   input  logic scale_lo,
   input  logic cont_rdy_f,
   input  logic dump_f,
   output logic fill_cmd,
   output logic gate_cmd,
   output logic weigh_f
);

   agg_st_e st, nx;

   always_comb begin
      nx = st;
      unique case (st)
         AG_FILL:  if (agg_full)                nx = AG_WEIGH;
         AG_WEIGH: if (scale_lo && cont_rdy_f)  nx = AG_SYNC;
         AG_SYNC:  if (!scale_lo && dump_f)     nx = AG_FILL;
         default:                               nx = AG_FILL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= AG_FILL;
      else     st <= nx;
   end

   assign weigh_f = (st == AG_WEIGH);

   generate
      if (OUT_REG == 1) begin : g_reg
         logic fill_q, gate_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               fill_q <= 1'b1;
               gate_q <= 1'b0;
            end else begin
               fill_q <= (nx == AG_FILL);
               gate_q <= (nx == AG_WEIGH);
            end
         end
         assign fill_cmd = fill_q;
         assign gate_cmd = gate_q;
      end else begin : g_dec
         assign fill_cmd = (st == AG_FILL);
         assign gate_cmd = (st == AG_WEIGH);
      end
   endgenerate

   // R2
   agg_fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
      fill_cmd && !agg_full |=> fill_cmd);

endmodule

// File: rtl/lsm_cnt_fsm.sv
module lsm_cnt_fsm
   import lsm_pkg::*;
#(
   parameter int unsigned OUT_REG = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic cont_full,
   input  logic scale_lo,
   input  logic scale_hi,
   input  logic agg_weigh_f,
   input  logic mix_idle_f,
   output logic fill_cmd,
   output logic gate_cmd,
   output logic dump_cmd,
   output logic ready_f,
   output logic weigh_f,
   output logic dump_f
);

   cnt_st_e st, nx;

   always_comb begin
      nx = st;
      unique case (st)
         CT_FILL:  if (cont_full)                nx = CT_READY;
         CT_READY: if (scale_lo && agg_weigh_f)  nx = CT_WEIGH;
         CT_WEIGH: if (scale_hi && mix_idle_f)   nx = CT_DUMP;
         CT_DUMP:  if (!scale_lo)                nx = CT_FILL;
         default:                                nx = CT_FILL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= CT_FILL;
      else     st <= nx;
   end

   assign ready_f = (st == CT_READY);
   assign weigh_f = (st == CT_WEIGH);
   assign dump_f  = (st == CT_DUMP);

   generate
      if (OUT_REG == 1) begin : g_reg
         logic fill_q, gate_q, dump_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               fill_q <= 1'b1;
               gate_q <= 1'b0;
               dump_q <= 1'b0;
            end else begin
               fill_q <= (nx == CT_FILL);
               gate_q <= (nx == CT_WEIGH);
               dump_q <= (nx == CT_DUMP);
            end
         end
         assign fill_cmd = fill_q;
         assign gate_cmd = gate_q;
         assign dump_cmd = dump_q;
      end else begin : g_dec
         assign fill_cmd = (st == CT_FILL);
         assign gate_cmd = (st == CT_WEIGH);
         assign dump_cmd = (st == CT_DUMP);
      end
   endgenerate

   // R3
   cont_fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
      fill_cmd && !cont_full |=> fill_cmd);

   // R6
   dump_hold_chk: assert property (@(posedge clk) disable iff (rst)
      dump_cmd && scale_lo |=> dump_cmd);

endmodule

// File: rtl/lsm_mix_fsm.sv
module lsm_mix_fsm
   import lsm_pkg::*;
#(
   parameter int unsigned OUT_REG = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic scale_lo,
   input  logic scale_hi,
   input  logic mix_done,
   input  logic mix_empty,
   input  logic cnt_weigh_f,
   input  logic cnt_dump_f,
   output logic run_cmd,
   output logic drain_cmd,
   output logic idle_f
);

   mix_st_e st, nx;

   always_comb begin
      nx = st;
      unique case (st)
         MX_IDLE:   if (scale_hi && cnt_weigh_f)  nx = MX_CHARGE;
         MX_CHARGE: if (!scale_lo && cnt_dump_f)  nx = MX_RUN;
         MX_RUN:    if (mix_done)                 nx = MX_DRAIN;
         MX_DRAIN:  if (mix_empty)                nx = MX_IDLE;
         default:                                 nx = MX_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= MX_IDLE;
      else     st <= nx;
   end

   assign idle_f = (st == MX_IDLE);

   generate
      if (OUT_REG == 1) begin : g_reg
         logic run_q, drain_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               run_q   <= 1'b0;
               drain_q <= 1'b0;
            end else begin
               run_q   <= (nx == MX_RUN);
               drain_q <= (nx == MX_DRAIN);
            end
         end
         assign run_cmd   = run_q;
         assign drain_cmd = drain_q;
      end else begin : g_dec
         assign run_cmd   = (st == MX_RUN);
         assign drain_cmd = (st == MX_DRAIN);
      end
   endgenerate

   // R7
   mix_run_hold_chk: assert property (@(posedge clk) disable iff (rst)
      run_cmd && !mix_done |=> run_cmd);

   // R7
   drain_follows_run_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(drain_cmd) |-> $past(run_cmd));

endmodule

// File: rtl/lsm_batch_ctrl.sv
module lsm_batch_ctrl #(
   parameter int unsigned OUT_REG = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic agg_full,
   input  logic cont_full,
   input  logic scale_lo,
   input  logic scale_hi,
   input  logic mix_done,
   input  logic mix_empty,
   output logic fill_agg,
   output logic fill_cont,
   output logic scale_gate,
   output logic scale_dump,
   output logic mix_run,
   output logic mix_drain
);

   if (OUT_REG > 1) begin : g_bad_param
      $error("OUT_REG must be 0 or 1");
   end

   // place flags exchanged between the machines
   logic f_agg_weigh, f_cnt_ready, f_cnt_weigh, f_cnt_dump, f_mix_idle;
   logic gate_agg, gate_cnt;

   lsm_agg_fsm #(.OUT_REG(OUT_REG)) u_agg (
      .clk        (clk),
      .rst        (rst),
      .agg_full   (agg_full),
      .scale_lo   (scale_lo),
      .cont_rdy_f (f_cnt_ready),
      .dump_f     (f_cnt_dump),
      .fill_cmd   (fill_agg),
      .gate_cmd   (gate_agg),
      .weigh_f    (f_agg_weigh)
   );

   lsm_cnt_fsm #(.OUT_REG(OUT_REG)) u_cnt (
      .clk         (clk),
      .rst         (rst),
      .cont_full   (cont_full),
      .scale_lo    (scale_lo),
      .scale_hi    (scale_hi),
      .agg_weigh_f (f_agg_weigh),
      .mix_idle_f  (f_mix_idle),
      .fill_cmd    (fill_cont),
      .gate_cmd    (gate_cnt),
      .dump_cmd    (scale_dump),
      .ready_f     (f_cnt_ready),
      .weigh_f     (f_cnt_weigh),
      .dump_f      (f_cnt_dump)
   );

   lsm_mix_fsm #(.OUT_REG(OUT_REG)) u_mix (
      .clk         (clk),
      .rst         (rst),
      .scale_lo    (scale_lo),
      .scale_hi    (scale_hi),
      .mix_done    (mix_done),
      .mix_empty   (mix_empty),
      .cnt_weigh_f (f_cnt_weigh),
      .cnt_dump_f  (f_cnt_dump),
      .run_cmd     (mix_run),
      .drain_cmd   (mix_drain),
      .idle_f      (f_mix_idle)
   );

   // shared command merged across machines
   assign scale_gate = gate_agg | gate_cnt;

   // R10
   gate_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(gate_agg && gate_cnt));

   // R4
   join_weigh_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(f_cnt_ready) |-> $fell(f_agg_weigh));

   // R5
   join_dump_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(f_cnt_dump) |-> $past(f_mix_idle));

   // R6
   fork_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(f_cnt_dump) |-> !f_mix_idle && !f_agg_weigh);

endmodule

// File: tb/lsm_batch_ctrl_tb.sv
module lsm_batch_ctrl_tb;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic agg_full = 0, cont_full = 0, scale_lo = 0, scale_hi = 0;
   logic mix_done = 0, mix_empty = 0;
   logic fill_agg, fill_cont, scale_gate, scale_dump, mix_run, mix_drain;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   lsm_batch_ctrl u_dut (
      .clk(clk), .rst(rst),
      .agg_full(agg_full), .cont_full(cont_full),
      .scale_lo(scale_lo), .scale_hi(scale_hi),
      .mix_done(mix_done), .mix_empty(mix_empty),
      .fill_agg(fill_agg), .fill_cont(fill_cont),
      .scale_gate(scale_gate), .scale_dump(scale_dump),
      .mix_run(mix_run), .mix_drain(mix_drain)
   );

   // {agg_full,cont_full,scale_lo,scale_hi,mix_done,mix_empty}
   // -> {fill_agg,fill_cont,scale_gate,scale_dump,mix_run,mix_drain}
   localparam int NV = 21;
   localparam logic [15:0] VEC [NV] = '{
      {4'd9,  6'b000011, 6'b110000},  // R9 idle sensors ignored
      {4'd9,  6'b000000, 6'b110000},  // R9
      {4'd2,  6'b100000, 6'b011000},  // R2
      {4'd4,  6'b001000, 6'b011000},  // R4 join blocked
      {4'd3,  6'b010000, 6'b001000},  // R3
      {4'd9,  6'b000100, 6'b001000},  // R9
      {4'd4,  6'b001000, 6'b001000},  // R4 join fires
      {4'd5,  6'b001100, 6'b000100},  // R5
      {4'd6,  6'b001000, 6'b000100},  // R6 dump holds
      {4'd6,  6'b000000, 6'b110010},  // R6 fork
      {4'd8,  6'b100000, 6'b011010},  // R8
      {4'd8,  6'b010000, 6'b001010},  // R8
      {4'd10, 6'b001000, 6'b001010},  // R10
      {4'd5,  6'b001100, 6'b001010},  // R5 mixer busy
      {4'd7,  6'b001110, 6'b001001},  // R7
      {4'd7,  6'b001101, 6'b001000},  // R7
      {4'd5,  6'b001100, 6'b000100},  // R5
      {4'd6,  6'b000010, 6'b110010},  // R6
      {4'd7,  6'b000010, 6'b110001},  // R7
      {4'd7,  6'b000001, 6'b110000},  // R7
      {4'd9,  6'b000000, 6'b110000}   // R9
   };

   function automatic logic [5:0] outs();
      return {fill_agg, fill_cont, scale_gate, scale_dump, mix_run, mix_drain};
   endfunction

   task automatic check(input int req, input logic [5:0] exp);
      total++;
      if (outs() !== exp) begin
         bad++;
         $display("FAIL R%0d: outputs=%b expected=%b", req, outs(), exp);
      end
   endtask

   task automatic drive(input logic [5:0] s);
      {agg_full, cont_full, scale_lo, scale_hi, mix_done, mix_empty} = s;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         total++;
         bad++;
         $display("FAIL watchdog: cycles=%0d expected<=20000", cyc);
         finish_run();
      end
   end

   int agg_lvl, cnt_lvl, wt, mt, ml;
   int batches, overlap, order_err;
   bit saw_dump, prev_mix, prev_drain;

   initial begin
      drive(6'b0);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(1, 6'b110000);  // R1 reset state

      rst = 1'b0;
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][11:6]);
         @(posedge clk);
         @(negedge clk);
         check(int'(VEC[i][15:12]), VEC[i][5:0]);
      end

      // R1 reset in mid-run: bring to weighing, then reset
      drive(6'b100000);
      @(negedge clk);
      drive(6'b000000);
      @(negedge clk);
      check(2, 6'b011000);
      rst = 1'b1;
      @(negedge clk);
      check(1, 6'b110000);
      rst = 1'b0;

      // reactive plant run, R6 R7 R8
      drive(6'b0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      agg_lvl = 0; cnt_lvl = 0; wt = 0; mt = 0; ml = 0;
      batches = 0; overlap = 0; order_err = 0;
      saw_dump = 0; prev_mix = 0; prev_drain = 0;
      for (int c = 0; c < 800; c++) begin
         if (fill_agg) agg_lvl++; else if (scale_gate) agg_lvl = 0;
         if (fill_cont) cnt_lvl++; else if (scale_dump) cnt_lvl = 0;
         if (scale_gate && wt < 15) wt++;
         if (scale_dump) begin
            if (wt > 0) wt--;
            ml++;
         end
         if (mix_drain && ml > 0) ml--;
         if (mix_run) mt++; else mt = 0;
         if (scale_dump) saw_dump = 1;
         if (mix_run && !prev_mix) begin
            if (!saw_dump) order_err++;
            saw_dump = 0;
         end
         if (prev_drain && !mix_drain) batches++;
         if (mix_run && (fill_agg || (scale_gate && !fill_cont))) overlap++;
         prev_mix = mix_run;
         prev_drain = mix_drain;
         drive({agg_lvl >= 3, cnt_lvl >= 3, wt >= 4, wt >= 8, mt >= 5, ml == 0});
         @(negedge clk);
      end
      total++;
      if (order_err != 0) begin
         bad++;
         $display("FAIL R6: mix starts without dump=%0d expected=0", order_err);
      end
      total++;
      if (batches < 3) begin
         bad++;
         $display("FAIL R7: batches=%0d expected>=3", batches);
      end
      total++;
      if (overlap == 0) begin
         bad++;
         $display("FAIL R8: overlap cycles=%0d expected>0", overlap);
      end
      finish_run();
   end

endmodule